// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves 8-bit characters over the single open-drain I/O line of a contact smart card. It uses the asynchronous half-duplex character protocol of ISO/IEC 7816-3. The line is modelled as a drive-low output plus a sampled input. The line idles high, and each character occupies twelve elementary time units (ETUs) on the wire. One input selects between smart card mode and plain serial mode.

In smart card mode the line carries error handshakes in both directions:

- When the block receives a character whose parity is wrong, it pulls the line low for one ETU during the guard time, so the card repeats the character.
- When the block transmits and the card pulls the line low in the same window, the block sends the same character again, up to a programmable retry limit.

In plain serial mode neither handshake happens, and a bad parity on receive is reported to the host instead.

A direct/inverse selector changes the bit order and the line polarity of the data. The ETU length is 16 sample ticks. The sample tick comes from the system clock after a 1/4/16/64 prescaler and a programmable divider.

The host side is deliberately thin:

- a one-character transmit holding slot, written with a strobe;
- a receive data output with a read strobe;
- an error flag with a clear strobe;
- three level interrupt outputs: transmit slot empty, receive data full, and error.

Top module: `sc_xcvr`

## Requirements
- R1: A transmitted character has the following layout on the line, in order, each part lasting exactly one ETU. First a low start bit. Then eight data bits. Then a parity bit chosen so that the eight data bits plus parity, as they appear on the line, hold an even number of ones. Then two high guard ETUs. Transmission begins only on a sample tick.
- R2: Direct convention (`cfg_inverse`=0) sends data bit 0 first and uses true line levels. Inverse convention (`cfg_inverse`=1) sends data bit 7 first with every data bit inverted. The receiver undoes the same mapping.
- R3: One ETU equals 16 × P × (`cfg_brr`+1) clock cycles. P is 1, 4, 16 or 64 for `cfg_prescale` 0, 1, 2 or 3.
- R4: A character received with correct parity appears on `rx_rdata` and raises `irq_rxf`. The flag holds until an `rx_rd` pulse clears it.
- R5: In smart card mode (`cfg_smart`=1), a received character with bad parity is discarded. The block drives the line low from 10.5 to 11.5 ETU after the start edge, and it raises neither `irq_rxf` nor `irq_err`.
- R6: In plain serial mode, a received character with bad parity never causes a line drive, and it sets `irq_err`.
- R7: In smart card mode the transmitter samples the line 11 ETU after its start edge. A low level there makes it resend the same character, starting at 12 ETU. It does this at most `cfg_max_retry` times per character.
- R8: When the card still signals an error after the last allowed retry, the block sets `irq_err` and drops the character. It starts no transmission until `err_clr` is pulsed.
- R9: In plain serial mode the transmitter ignores an error signal from the card and sends each character once.
- R10: `irq_txe` is high while the transmit slot is empty. A `tx_wr` while the slot is full is ignored.
- R11: The line is used half duplex. The receiver ignores the line while a transmission is in progress. A pending transmission waits while a reception is in progress, and the received character stays intact.
- R12: `irq_err` stays set until `err_clr` is pulsed.
- R13: After reset `irq_txe` is 1, `irq_rxf` and `irq_err` are 0, and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_smart | input | 1 | 1 = smart card mode, 0 = plain serial mode |
| cfg_inverse | input | 1 | 1 = inverse convention, 0 = direct |
| cfg_prescale | input | 2 | Prescaler select: divide by 1, 4, 16, 64 |
| cfg_brr | input | BRR_W | Bit-rate divider value minus one |
| cfg_max_retry | input | RETRY_W | Maximum automatic resends per character |
| tx_wr | input | 1 | Write strobe for the transmit slot |
| tx_wdata | input | 8 | Character to transmit |
| rx_rd | input | 1 | Read strobe, clears receive-full |
| rx_rdata | output | 8 | Last received character |
| err_clr | input | 1 | Clears the error flag |
| irq_txe | output | 1 | Transmit slot empty |
| irq_rxf | output | 1 | Receive data full |
| irq_err | output | 1 | Communication error |
| io_in | input | 1 | Sampled level of the card I/O line |
| io_drive_low | output | 1 | Pulls the card I/O line low when 1 |

## Verification
The assertions rely on several assumptions about the inputs. Configuration inputs change only while no character is in flight, so the retry limit never drops below a count already reached. The far end of the line never starts a character while the block is driving it. The line input is a faithful copy of the wire. The bench keeps within these assumptions in three ways. It changes the mode, the convention, the prescaler and the divider only between characters, after the previous frame and its guard time have ended. Its card model starts a character only when it is not reading one. It resolves the wire as a wired-AND of the block's drive and the card's drive, which makes the block see its own and the card's low levels alike.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        PRE_DIV1  = 2'd0,
        PRE_DIV4  = 2'd1,
        PRE_DIV16 = 2'd2,
        PRE_DIV64 = 2'd3
    } prescale_e;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
    } char_slot_t;

    // terminal count of the prescaler for each selection
    function automatic logic [5:0] pre_limit(input prescale_e sel);
        case (sel)
            PRE_DIV1:  pre_limit = 6'd0;
            PRE_DIV4:  pre_limit = 6'd3;
            PRE_DIV16: pre_limit = 6'd15;
            default:   pre_limit = 6'd63;
        endcase
    endfunction

    // data byte -> line bits in send order (index 0 goes first)
    function automatic logic [CHAR_W-1:0] to_line(input logic [CHAR_W-1:0] d, input logic inv);
        for (int i = 0; i < CHAR_W; i++)
            to_line[i] = inv ? ~d[CHAR_W-1-i] : d[i];
    endfunction

    // line bits in receive order -> data byte
    function automatic logic [CHAR_W-1:0] from_line(input logic [CHAR_W-1:0] l, input logic inv);
        for (int i = 0; i < CHAR_W; i++) begin
            if (inv) from_line[CHAR_W-1-i] = ~l[i];
            else     from_line[i]          = l[i];
        end
    endfunction

    function automatic logic even_par(input logic [CHAR_W-1:0] l);
        even_par = ^l;
    endfunction

endpackage

// File: rtl/sc_bitclk.sv
module sc_bitclk
    import sc_pkg::*;
#(
    parameter int BRR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  prescale_e        pre_sel,
    input  logic [BRR_W-1:0] brr,
    output logic             tick
);
    logic [5:0]       pre_cnt;
    logic             pre_tick;
    logic [BRR_W-1:0] div_cnt;

    assign pre_tick = (pre_cnt >= pre_limit(pre_sel));

    always_ff @(posedge clk) begin
        if (rst)           pre_cnt <= '0;
        else if (pre_tick) pre_cnt <= '0;
        else               pre_cnt <= pre_cnt + 6'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (pre_tick) begin
                if (div_cnt >= brr) begin
                    div_cnt <= '0;
                    tick    <= 1'b1;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sc_tx.sv
module sc_tx
    import sc_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int RETRY_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               smart,
    input  logic               inverse,
    input  logic [RETRY_W-1:0] max_retry,
    input  logic               line_in,
    input  logic               start,
    input  logic [CHAR_W-1:0]  start_data,
    output logic               accept,
    output logic               busy,
    output logic               drive_low,
    output logic               fail,
    output logic [RETRY_W-1:0] retry_cnt
);
    localparam int SUB_W = $clog2(OSR);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
    localparam logic [3:0] ETU_PAR  = 4'd9;
    localparam logic [3:0] ETU_CHK  = 4'd11;
    localparam logic [3:0] ETU_LAST = 4'd11;

    logic [3:0]       etu;
    logic [SUB_W-1:0] sub;
    logic [CHAR_W:0]  bits;
    logic             err_seen;
    logic [3:0]       bit_idx;
    logic             level;
    logic [CHAR_W-1:0] conv;

    assign accept  = tick && !busy && start;
    assign conv    = to_line(start_data, inverse);
    assign bit_idx = etu - 4'd1;

    always_comb begin
        level = 1'b1;
        if (busy) begin
            if (etu == 4'd0)         level = 1'b0;
            else if (etu <= ETU_PAR) level = bits[bit_idx];
        end
    end
    assign drive_low = !level;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            etu       <= '0;
            sub       <= '0;
            bits      <= '0;
            err_seen  <= 1'b0;
            retry_cnt <= '0;
            fail      <= 1'b0;
        end else begin
            fail <= 1'b0;
            if (!busy) begin
                retry_cnt <= '0;
                if (accept) begin
                    busy     <= 1'b1;
                    etu      <= '0;
                    sub      <= '0;
                    bits     <= {even_par(conv), conv};
                    err_seen <= 1'b0;
                end
            end else if (tick) begin
                if (smart && etu == ETU_CHK && sub == '0)
                    err_seen <= !line_in;
                if (sub == SUB_LAST) begin
                    sub <= '0;
                    if (etu == ETU_LAST) begin
                        if (smart && err_seen) begin
                            if (retry_cnt < max_retry) begin
                                retry_cnt <= retry_cnt + 1'b1;
                                etu       <= '0;
                                err_seen  <= 1'b0;
                            end else begin
                                busy <= 1'b0;
                                fail <= 1'b1;
                            end
                        end else begin
                            busy <= 1'b0;
                        end
                    end else begin
                        etu <= etu + 4'd1;
                    end
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sc_rx.sv
module sc_rx
    import sc_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              enable,
    input  logic              smart,
    input  logic              inverse,
    input  logic              line_in,
    output logic              busy,
    output logic              drive_low,
    output logic              got,
    output logic [CHAR_W-1:0] data,
    output logic              perr
);
    localparam int SUB_W = $clog2(OSR);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OSR / 2);

    logic [3:0]        etu;
    logic [SUB_W-1:0]  sub;
    logic [CHAR_W-1:0] sh;
    logic              nack;
    logic [3:0]        bit_idx;
    logic              bad;

    assign bit_idx = etu - 4'd1;
    assign bad     = even_par(sh) ^ line_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            etu       <= '0;
            sub       <= '0;
            sh        <= '0;
            nack      <= 1'b0;
            drive_low <= 1'b0;
            got       <= 1'b0;
            data      <= '0;
            perr      <= 1'b0;
        end else begin
            got  <= 1'b0;
            perr <= 1'b0;
            if (!busy) begin
                if (tick && enable && !line_in) begin
                    busy <= 1'b1;
                    etu  <= '0;
                    sub  <= SUB_W'(1);
                    nack <= 1'b0;
                end
            end else if (tick) begin
                if (sub == SUB_LAST) begin
                    sub <= '0;
                    etu <= etu + 4'd1;
                end else begin
                    sub <= sub + 1'b1;
                end
                if (sub == SUB_MID) begin
                    if (etu == 4'd0) begin
                        if (line_in) busy <= 1'b0;
                    end else if (etu <= 4'd8) begin
                        sh[bit_idx[2:0]] <= line_in;
                    end else if (etu == 4'd9) begin
                        if (!bad) begin
                            got  <= 1'b1;
                            data <= from_line(sh, inverse);
                        end else if (smart) begin
                            nack <= 1'b1;
                        end else begin
                            perr <= 1'b1;
                        end
                    end else if (etu == 4'd10) begin
                        if (nack) drive_low <= 1'b1;
                        else      busy      <= 1'b0;
                    end else begin
                        drive_low <= 1'b0;
                        busy      <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sc_xcvr.sv
module sc_xcvr
    import sc_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int BRR_W   = 8,
    parameter int RETRY_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_smart,
    input  logic               cfg_inverse,
    input  logic [1:0]         cfg_prescale,
    input  logic [BRR_W-1:0]   cfg_brr,
    input  logic [RETRY_W-1:0] cfg_max_retry,
    input  logic               tx_wr,
    input  logic [7:0]         tx_wdata,
    input  logic               rx_rd,
    output logic [7:0]         rx_rdata,
    input  logic               err_clr,
    output logic               irq_txe,
    output logic               irq_rxf,
    output logic               irq_err,
    input  logic               io_in,
    output logic               io_drive_low
);
    logic line_meta, line_s;
    logic tick;
    char_slot_t hold;
    logic tx_busy, tx_drv, tx_fail, tx_accept, tx_req;
    logic [RETRY_W-1:0] tx_retry;
    logic rx_busy, rx_drv, rx_got, rx_perr, rx_en;
    logic [CHAR_W-1:0] rx_char;
    logic err_q, rxf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_meta <= 1'b1;
            line_s    <= 1'b1;
        end else begin
            line_meta <= io_in;
            line_s    <= line_meta;
        end
    end

    sc_bitclk #(.BRR_W(BRR_W)) bitclk_i (
        .clk     (clk),
        .rst     (rst),
        .pre_sel (prescale_e'(cfg_prescale)),
        .brr     (cfg_brr),
        .tick    (tick)
    );

    assign tx_req = hold.valid && !rx_busy && !err_q;
    assign rx_en  = !tx_busy && !tx_accept;

    sc_tx #(.OSR(OSR), .RETRY_W(RETRY_W)) tx_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .smart      (cfg_smart),
        .inverse    (cfg_inverse),
        .max_retry  (cfg_max_retry),
        .line_in    (line_s),
        .start      (tx_req),
        .start_data (hold.data),
        .accept     (tx_accept),
        .busy       (tx_busy),
        .drive_low  (tx_drv),
        .fail       (tx_fail),
        .retry_cnt  (tx_retry)
    );

    sc_rx #(.OSR(OSR)) rx_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .enable    (rx_en),
        .smart     (cfg_smart),
        .inverse   (cfg_inverse),
        .line_in   (line_s),
        .busy      (rx_busy),
        .drive_low (rx_drv),
        .got       (rx_got),
        .data      (rx_char),
        .perr      (rx_perr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (tx_accept) begin
            hold.valid <= 1'b0;
        end else if (tx_wr && !hold.valid) begin
            hold.valid <= 1'b1;
            hold.data  <= tx_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxf_q    <= 1'b0;
            rx_rdata <= '0;
            err_q    <= 1'b0;
        end else begin
            if (rx_got) begin
                rxf_q    <= 1'b1;
                rx_rdata <= rx_char;
            end else if (rx_rd) begin
                rxf_q <= 1'b0;
            end
            if (tx_fail || rx_perr) err_q <= 1'b1;
            else if (err_clr)       err_q <= 1'b0;
        end
    end

    assign irq_txe      = !hold.valid;
    assign irq_rxf      = rxf_q;
    assign irq_err      = err_q;
    assign io_drive_low = tx_drv || rx_drv;
endmodule

// File: rtl/sc_xcvr_chk.sv
module sc_xcvr_chk #(
    parameter int RETRY_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               tx_busy,
    input logic               rx_busy,
    input logic               rx_drv,
    input logic [RETRY_W-1:0] tx_retry,
    input logic [RETRY_W-1:0] cfg_max_retry,
    input logic               cfg_smart,
    input logic               irq_err,
    input logic               err_clr
);
    // R11
    half_duplex_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_busy && rx_busy));

    // R7
    retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tx_retry <= cfg_max_retry);

    // R6
    nack_smart_only_chk: assert property (@(posedge clk) disable iff (rst)
        rx_drv |-> cfg_smart);

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        irq_err && !err_clr |=> irq_err);

    // R8
    err_blocks_tx_chk: assert property (@(posedge clk) disable iff (rst)
        irq_err && !tx_busy |=> !tx_busy);

    // R7
    retry_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |=> (tx_retry == '0) || tx_busy);
endmodule

bind sc_xcvr sc_xcvr_chk #(.RETRY_W(RETRY_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .tx_busy       (tx_busy),
    .rx_busy       (rx_busy),
    .rx_drv        (rx_drv),
    .tx_retry      (tx_retry),
    .cfg_max_retry (cfg_max_retry),
    .cfg_smart     (cfg_smart),
    .irq_err       (irq_err),
    .err_clr       (err_clr)
);

// File: tb/sc_xcvr_tb_top.sv
`timescale 1ns/1ps
module sc_xcvr_tb_top;
    localparam int OSR = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       cfg_smart = 1'b1, cfg_inverse = 1'b0;
    logic [1:0] cfg_prescale = 2'd0;
    logic [7:0] cfg_brr = 8'd1;
    logic [2:0] cfg_max_retry = 3'd3;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, err_clr = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic [7:0] rx_rdata;
    logic       irq_txe, irq_rxf, irq_err, io_drive_low;
    logic       card_low = 1'b0;
    logic       io_line;

    assign io_line = !(io_drive_low || card_low);

    sc_xcvr dut_i (
        .clk(clk), .rst(rst), .cfg_smart(cfg_smart), .cfg_inverse(cfg_inverse),
        .cfg_prescale(cfg_prescale), .cfg_brr(cfg_brr), .cfg_max_retry(cfg_max_retry),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .err_clr(err_clr), .irq_txe(irq_txe), .irq_rxf(irq_rxf), .irq_err(irq_err),
        .io_in(io_line), .io_drive_low(io_drive_low)
    );

    int nvec = 0, nfail = 0;
    int etu = 32;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int calc_etu();
        return OSR * (1 << (2 * int'(cfg_prescale))) * (int'(cfg_brr) + 1);
    endfunction

    function automatic logic [7:0] enc(input logic [7:0] d, input logic inv);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = inv ? ~d[7-i] : d[i];
        return r;
    endfunction

    function automatic logic [8:0] frame_bits(input logic [7:0] d, input logic inv);
        logic [7:0] l = enc(d, inv);
        return {^l, l};
    endfunction

    function automatic logic [7:0] pat(input int k);
        if (k == 0) return 8'h00;
        if (k == 1) return 8'hFF;
        return 8'((k * 53 + 7) & 255);
    endfunction

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    // card side reader: waits for a start edge, samples 9 bits, optional error signal
    task automatic card_rx(input bit nack, output bit seen, output logic [8:0] bits);
        seen = 1'b0;
        bits = '0;
        for (int t = 0; t < 40 * etu && !seen; t++) begin
            @(negedge clk);
            if (!io_line) seen = 1'b1;
        end
        if (seen) begin
            repeat (etu / 2) @(negedge clk);
            for (int i = 0; i < 9; i++) begin
                repeat (etu) @(negedge clk);
                bits[i] = io_line;
            end
            repeat (etu) @(negedge clk);
            if (nack) begin
                card_low = 1'b1;
                repeat (etu) @(negedge clk);
                card_low = 1'b0;
            end
        end
    endtask

    // card side writer: start, 8 data, parity (optionally wrong), guard; samples error window
    task automatic card_tx(input logic [7:0] d, input bit bad_par, output bit nack_seen);
        logic [7:0] l = enc(d, cfg_inverse);
        logic p = (^l) ^ bad_par;
        @(negedge clk);
        card_low = 1'b1;
        repeat (etu) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            card_low = !l[i];
            repeat (etu) @(negedge clk);
        end
        card_low = !p;
        repeat (etu) @(negedge clk);
        card_low = 1'b0;
        repeat (etu) @(negedge clk);
        nack_seen = !io_line;
        repeat (2 * etu) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        bit s, s2, nk;
        logic [8:0] b, b2;
        int cnt;
        bit drove;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R13 reset state
        chk(irq_txe == 1'b1, "R13 irq_txe", irq_txe, 1);
        chk(irq_rxf == 1'b0, "R13 irq_rxf", irq_rxf, 0);
        chk(irq_err == 1'b0, "R13 irq_err", irq_err, 0);
        chk(io_drive_low == 1'b0, "R13 line released", io_drive_low, 0);
        etu = calc_etu();

        // R1 R2: transmit sweep in both conventions
        for (int inv = 0; inv < 2; inv++) begin
            cfg_inverse = inv[0];
            for (int k = 0; k < 24; k++) begin
                host_write(pat(k));
                card_rx(1'b0, s, b);
                chk(s && b == frame_bits(pat(k), inv[0]), "R1 R2 tx frame", int'(b),
                    int'(frame_bits(pat(k), inv[0])));
            end
        end
        repeat (3 * etu) @(negedge clk);

        // R4 R2: receive sweep in both conventions
        for (int inv = 0; inv < 2; inv++) begin
            cfg_inverse = inv[0];
            for (int k = 0; k < 24; k++) begin
                card_tx(pat(k), 1'b0, nk);
                chk(irq_rxf == 1'b1, "R4 irq_rxf set", irq_rxf, 1);
                chk(rx_rdata == pat(k), "R2 R4 rx data", rx_rdata, pat(k));
                pulse_rd();
                chk(irq_rxf == 1'b0, "R4 irq_rxf cleared", irq_rxf, 0);
            end
        end
        cfg_inverse = 1'b0;

        // R3: bit time over prescaler and divider settings
        for (int sel = 0; sel < 4; sel++) begin
            for (int br = 0; br < 2; br++) begin
                cfg_prescale = 2'(sel);
                cfg_brr = 8'(br);
                etu = calc_etu();
                host_write(8'h01);
                s = 1'b0;
                for (int t = 0; t < 4 * etu && !s; t++) begin
                    @(negedge clk);
                    if (!io_line) s = 1'b1;
                end
                cnt = 0;
                while (!io_line && cnt < 4 * etu) begin
                    cnt++;
                    @(negedge clk);
                end
                chk(s && cnt == etu, "R3 etu length", cnt, etu);
                repeat (12 * etu) @(negedge clk);
            end
        end
        cfg_prescale = 2'd0;
        cfg_brr = 8'd1;
        etu = calc_etu();

        // R7: two error signals, then accepted
        cfg_max_retry = 3'd3;
        host_write(8'hA5);
        for (int f = 0; f < 3; f++) begin
            card_rx(f < 2, s, b);
            chk(s && b == frame_bits(8'hA5, 1'b0), "R7 resend", int'(b), int'(frame_bits(8'hA5, 1'b0)));
        end
        card_rx(1'b0, s, b);
        chk(!s, "R7 no extra frame", s, 0);
        chk(irq_err == 1'b0, "R7 no error", irq_err, 0);

        // R8 R12: retries exhausted
        cfg_max_retry = 3'd2;
        host_write(8'h3C);
        for (int f = 0; f < 3; f++) begin
            card_rx(1'b1, s, b);
            chk(s && b == frame_bits(8'h3C, 1'b0), "R8 attempt", int'(b), int'(frame_bits(8'h3C, 1'b0)));
        end
        card_rx(1'b0, s, b);
        chk(!s, "R8 stops after limit", s, 0);
        chk(irq_err == 1'b1, "R8 irq_err", irq_err, 1);
        host_write(8'h96);
        chk(irq_txe == 1'b0, "R10 slot held", irq_txe, 0);
        card_rx(1'b0, s, b);
        chk(!s, "R8 blocked while error", s, 0);
        chk(irq_err == 1'b1, "R12 sticky", irq_err, 1);
        pulse_clr();
        chk(irq_err == 1'b0, "R12 cleared", irq_err, 0);
        card_rx(1'b0, s, b);
        chk(s && b == frame_bits(8'h96, 1'b0), "R8 resumes", int'(b), int'(frame_bits(8'h96, 1'b0)));

        // R9: plain mode ignores error signal
        cfg_smart = 1'b0;
        repeat (2 * etu) @(negedge clk);
        host_write(8'h5A);
        card_rx(1'b1, s, b);
        chk(s && b == frame_bits(8'h5A, 1'b0), "R9 frame", int'(b), int'(frame_bits(8'h5A, 1'b0)));
        card_rx(1'b0, s, b);
        chk(!s, "R9 no resend", s, 0);
        chk(irq_err == 1'b0, "R9 no error", irq_err, 0);

        // R6: plain mode parity error
        card_tx(8'h77, 1'b1, nk);
        chk(!nk, "R6 no error signal", nk, 0);
        chk(irq_err == 1'b1, "R6 irq_err", irq_err, 1);
        chk(irq_rxf == 1'b0, "R6 discarded", irq_rxf, 0);
        pulse_clr();
        card_tx(8'h81, 1'b0, nk);
        chk(rx_rdata == 8'h81 && irq_rxf, "R4 plain mode rx", rx_rdata, 8'h81);
        pulse_rd();

        // R5: smart mode parity error
        cfg_smart = 1'b1;
        repeat (2 * etu) @(negedge clk);
        card_tx(8'h42, 1'b1, nk);
        chk(nk, "R5 error signal driven", nk, 1);
        chk(irq_rxf == 1'b0, "R5 discarded", irq_rxf, 0);
        chk(irq_err == 1'b0, "R5 no irq", irq_err, 0);

        // R10: write while slot full is dropped
        fork
            card_rx(1'b0, s, b);
            begin
                host_write(8'h11);
                repeat (4) @(negedge clk);
                chk(irq_txe == 1'b1, "R10 slot empty", irq_txe, 1);
                host_write(8'h22);
                chk(irq_txe == 1'b0, "R10 slot full", irq_txe, 0);
                host_write(8'h33);
            end
        join
        chk(s && b == frame_bits(8'h11, 1'b0), "R10 first", int'(b), int'(frame_bits(8'h11, 1'b0)));
        card_rx(1'b0, s, b);
        chk(s && b == frame_bits(8'h22, 1'b0), "R10 second", int'(b), int'(frame_bits(8'h22, 1'b0)));
        card_rx(1'b0, s, b);
        chk(!s, "R10 third dropped", s, 0);

        // R11: transmit request during a reception waits
        drove = 1'b0;
        fork
            card_tx(8'hC3, 1'b0, nk);
            begin
                repeat (2 * etu) @(negedge clk);
                host_write(8'hE7);
                for (int t = 0; t < 8 * etu; t++) begin
                    @(negedge clk);
                    if (io_drive_low) drove = 1'b1;
                end
                repeat (etu / 4) @(negedge clk);
                card_rx(1'b0, s2, b2);
            end
        join
        chk(!drove, "R11 no drive during rx", drove, 0);
        chk(rx_rdata == 8'hC3, "R11 rx intact", rx_rdata, 8'hC3);
        chk(s2 && b2 == frame_bits(8'hE7, 1'b0), "R11 deferred tx", int'(b2), int'(frame_bits(8'hE7, 1'b0)));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule